// File: doc/BRIEF.md
# Capacity bar display driver

This block turns a charge count into a five-segment LED bar and a 4-bit gauge value. Each lit segment stands for one fifth of a fixed full-scale count. The raw charge is first derated for cold. The cold state has hysteresis, so readings near freezing do not flicker. When the charge is low, the first segment blinks.

The bar is shown only when it is asked for. A button press shows it for a fixed time. It is also shown while charging is active. During fast discharge or overload it is shown too, and for a longer hold time after that ends. Odd and even segments are driven in two alternating banks, and the common enable is on only while a bank is driven.

A host test mode replaces the bar with a five-bit pattern. All times come from one prescaler parameter, `TICK_DIV`. It sets the clock cycles per tick, and a tick is one tenth of a multiplex frame.

Top module: `capgauge_leds`

## Requirements
- R1: Async reset darkens all segments (`seg_n` = 5'b11111) and turns `com_en` off. For the first 10 ticks after reset, `com_en` stays off even when the display is active.
- R2: The number of lit bar segments is min(5, floor(5·A/F)), where A is the derated charge and F is `full_ref`. Segment k (bit k-1) is lit when that count is at least k. F = 0 gives no segments.
- R3: `gauge` = min(15, floor(16·A/F)), and it is 0 when F = 0. It is valid whether or not the display is active.
- R4: The derating factor is 1 when warm. In the cold state it is 3/4, or 1/2 when `temp_c` < -20.
- R5: A registered cold state is entered when `temp_c` < 0 and left when `temp_c` >= 4. It takes effect in the cycle after the temperature is sampled.
- R6: A frame is 10 ticks. Segments 1, 3 and 5 (bits 0, 2, 4) may be driven in ticks 0–2. Segments 2 and 4 (bits 1, 3) may be driven in ticks 5–7. `com_en` is on in those six ticks only.
- R7: The battery is low when `eod` is high or 10·`avail` < `full_ref`. When low, segment 1 follows a blink phase instead of the bar. The phase starts lit after reset and toggles every 400 ticks.
- R8: A falling edge on `btn_n` activates the display for 12800 ticks.
- R9: The display is active while `fdis_act` or `ovld` is high, and for 32000 ticks after both drop.
- R10: The display is active while `chg_act` is high.
- R11: With `oce` high, the segment pattern is `oc` (bit 0 = segment 1) and the display is forced active. Bank timing still applies.
- R12: An inactive display drives no segment and keeps `com_en` off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| avail | input | CW | Available charge count |
| full_ref | input | CW | Full-scale reference count |
| temp_c | input | 8 | Signed temperature, °C |
| eod | input | 1 | End-of-discharge flag |
| chg_act | input | 1 | Charge activity level |
| fdis_act | input | 1 | Fast-discharge activity level |
| ovld | input | 1 | Overload detect |
| btn_n | input | 1 | Push-button request, active low |
| oce | input | 1 | Host output override enable |
| oc | input | 5 | Override segment pattern |
| seg_n | output | 5 | Segment drives, active low, bit 0 = segment 1 |
| com_en | output | 1 | Common drive enable |
| gauge | output | 4 | Capacity in sixteenths |

## Verification
A wrong slot or blink counter shows up within one frame as a lit segment in the wrong bank, or as a wrong duty count over a window. A wrong cold state or a wrong quotient changes `gauge` in the very next cycle. A timer that is off by even one tick shows up at the exact cycle the display goes dark, because the bench runs a reference model and compares all outputs on every clock through the whole 12800-tick and 32000-tick windows.

// File: rtl/capgauge_leds.sv
module capgauge_leds #(
  parameter int CW       = 16,
  parameter int TICK_DIV = 15625
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     avail,
  input  logic [CW-1:0]     full_ref,
  input  logic signed [7:0] temp_c,
  input  logic              eod,
  input  logic              chg_act,
  input  logic              fdis_act,
  input  logic              ovld,
  input  logic              btn_n,
  input  logic              oce,
  input  logic [4:0]        oc,
  output logic [4:0]        seg_n,
  output logic              com_en,
  output logic [3:0]        gauge
);
  localparam int BLINK_TICKS = 400;
  localparam int PUSH_TICKS  = 12800;
  localparam int HOLD_TICKS  = 32000;
  localparam int INIT_TICKS  = 10;
  localparam int AW  = CW + 6;
  localparam int PW  = $clog2(TICK_DIV) + 1;
  localparam int BW  = $clog2(BLINK_TICKS);
  localparam int UW  = $clog2(PUSH_TICKS + 1);
  localparam int HW  = $clog2(HOLD_TICKS + 1);
  localparam int IW  = $clog2(INIT_TICKS + 1);

  logic [PW-1:0] pre;
  logic [3:0]    slot;
  logic [BW-1:0] bcnt;
  logic          bph, btn_q, cold, tick;
  logic [UW-1:0] push_t;
  logic [HW-1:0] hold_t;
  logic [IW-1:0] init_t;

  assign tick = (pre == PW'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre    <= '0;
      slot   <= '0;
      bcnt   <= '0;
      bph    <= 1'b1;
      init_t <= IW'(INIT_TICKS);
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      if (tick) begin
        slot <= (slot == 4'd9) ? 4'd0 : slot + 4'd1;
        if (bcnt == BW'(BLINK_TICKS - 1)) begin
          bcnt <= '0;
          bph  <= ~bph;
        end else begin
          bcnt <= bcnt + 1'b1;
        end
        if (init_t != '0) init_t <= init_t - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push_t <= '0;
      hold_t <= '0;
      btn_q  <= 1'b1;
      cold   <= 1'b0;
    end else begin
      btn_q <= btn_n;
      if (btn_q && !btn_n)            push_t <= UW'(PUSH_TICKS);
      else if (tick && push_t != '0)  push_t <= push_t - 1'b1;
      if (fdis_act || ovld)           hold_t <= HW'(HOLD_TICKS);
      else if (tick && hold_t != '0)  hold_t <= hold_t - 1'b1;
      cold <= cold ? (temp_c < 8'sd4) : (temp_c < 8'sd0);
    end
  end

  logic [2:0]    scale, lvl;
  logic [AW-1:0] prod, q5, q16;
  logic [4:0]    bar, pat, on;
  logic          low, active, drive, bank_a, bank_b;

  assign scale = !cold ? 3'd4 : (temp_c < -8'sd20) ? 3'd2 : 3'd3;
  assign prod  = AW'(avail) * AW'(scale);
  assign q5    = (full_ref == '0) ? '0 : (prod * AW'(5)) / AW'({full_ref, 2'b00});
  assign q16   = (full_ref == '0) ? '0 : (prod << 2) / AW'(full_ref);
  assign lvl   = (q5 > AW'(5)) ? 3'd5 : q5[2:0];
  assign gauge = (q16 > AW'(15)) ? 4'd15 : q16[3:0];
  assign low   = eod || (AW'(avail) * AW'(10) < AW'(full_ref));

  assign pat    = oce ? oc : {bar[4:1], low ? bph : bar[0]};
  assign active = oce || chg_act || fdis_act || ovld || push_t != '0 || hold_t != '0;
  assign drive  = active && init_t == '0;
  assign bank_a = slot < 4'd3;
  assign bank_b = slot >= 4'd5 && slot < 4'd8;
  assign com_en = drive && (bank_a || bank_b);
  assign seg_n  = ~on;

  for (genvar i = 0; i < 5; i++) begin : g_seg
    assign bar[i] = lvl > 3'(i);
    assign on[i]  = drive && pat[i] && ((i % 2 == 0) ? bank_a : bank_b);
  end
endmodule

// File: rtl/capgauge_leds_chk.sv
module capgauge_leds_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] full_ref,
  input logic          eod,
  input logic          oce,
  input logic [4:0]    oc,
  input logic [4:0]    seg_n,
  input logic          com_en,
  input logic [3:0]    gauge
);
  // R6
  bank_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((!seg_n[0] || !seg_n[2] || !seg_n[4]) && (!seg_n[1] || !seg_n[3])));
  // R12
  seg_needs_com_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_n != 5'b11111) |-> com_en);
  // R1
  init_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !com_en);
  // R2
  zero_ref_bar_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_ref == '0 && !oce && !eod) |-> (seg_n == 5'b11111));
  // R3
  zero_ref_gauge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_ref == '0) |-> (gauge == 4'd0));
  // R11
  override_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oce && !oc[0]) |-> seg_n[0]);
endmodule

bind capgauge_leds capgauge_leds_chk #(.CW(CW)) u_chk (.*);

// File: tb/capgauge_leds_bench.sv
module capgauge_leds_bench;
  localparam int TD = 2;
  logic clk = 0, rst_n = 0;
  logic [15:0] avail = 0, full_ref = 1000;
  logic signed [7:0] temp_c = 25;
  logic eod = 0, chg_act = 0, fdis_act = 0, ovld = 0, btn_n = 1, oce = 0;
  logic [4:0] oc = 0, seg_n;
  logic com_en;
  logic [3:0] gauge;

  capgauge_leds #(.CW(16), .TICK_DIV(TD)) u_capgauge_leds (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit go = 0, tk;
  string cur = "R1";
  int m_pre, m_slot, m_bc, m_bph, m_push, m_hold, m_init, m_btn, m_cold;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_slot = 0; m_bc = 0; m_bph = 1; m_push = 0;
      m_hold = 0; m_init = 10; m_btn = 1; m_cold = 0;
    end else begin
      tk = (m_pre == TD - 1);
      m_pre = tk ? 0 : m_pre + 1;
      if (tk) begin
        m_slot = (m_slot + 1) % 10;
        m_bc++;
        if (m_bc == 400) begin m_bc = 0; m_bph = !m_bph; end
        if (m_init > 0) m_init--;
      end
      if (m_btn == 1 && !btn_n) m_push = 12800;
      else if (tk && m_push > 0) m_push--;
      m_btn = btn_n;
      if (fdis_act || ovld) m_hold = 32000;
      else if (tk && m_hold > 0) m_hold--;
      m_cold = m_cold ? (temp_c < 4) : (temp_c < 0);
    end
  end

  task automatic see(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", r, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && go) begin
    int sc, lvl, gg, lowb, act, drv, ba, bb;
    logic [4:0] pat, es;
    sc = !m_cold ? 4 : (temp_c < -20 ? 2 : 3);
    if (full_ref == 0) begin lvl = 0; gg = 0; end
    else begin
      lvl = (int'(avail) * sc * 5) / (int'(full_ref) * 4);
      gg  = (int'(avail) * sc * 4) / int'(full_ref);
      if (lvl > 5) lvl = 5;
      if (gg > 15) gg = 15;
    end
    lowb = eod || (int'(avail) * 10 < int'(full_ref));
    for (int k = 0; k < 5; k++) pat[k] = (lvl > k);
    if (lowb) pat[0] = m_bph[0];
    if (oce) pat = oc;
    act = oce || chg_act || fdis_act || ovld || m_push > 0 || m_hold > 0;
    drv = act && m_init == 0;
    ba = m_slot < 3;
    bb = m_slot >= 5 && m_slot < 8;
    for (int k = 0; k < 5; k++)
      es[k] = !(drv && pat[k] && ((k % 2 == 0) ? ba : bb));
    see({cur, " seg_n"}, seg_n, es);
    see({cur, " com_en"}, com_en, drv && (ba || bb));
    see({cur, " gauge"}, gauge, gg);
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic win(input int n, output int cc, output int c0, output int c1);
    cc = 0; c0 = 0; c1 = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      if (com_en) cc++;
      if (!seg_n[0]) c0++;
      if (!seg_n[1]) c1++;
    end
  endtask

  task automatic probe(string r, int g);
    @(negedge clk); #1;
    see(r, gauge, g);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL all-requirements watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int cc, c0, c1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    see("R1 reset seg_n", seg_n, 31);
    see("R1 reset com_en", com_en, 0);
    @(posedge clk); #2;
    rst_n = 1; go = 1; chg_act = 1; avail = 600;
    @(negedge clk); #1;
    see("R1 init window com_en", com_en, 0);
    step(40);
    cur = "R2";
    probe("R3 gauge 600/1000", 9);
    win(40, cc, c0, c1);
    see("R10 charge shows display", cc, 24);
    avail = 1000; step(1);
    probe("R3 gauge full", 15);
    cur = "R6";
    win(40, cc, c0, c1);
    see("R6 com duty", cc, 24);
    see("R6 bank A seg1 duty", c0, 12);
    see("R6 bank B seg2 duty", c1, 12);
    cur = "R2";
    avail = 1200; step(1); probe("R3 gauge capped", 15);
    avail = 199;  step(1); win(40, cc, c0, c1); see("R2 below one fifth", c0, 0);
    avail = 200;  step(1); win(40, cc, c0, c1); see("R2 exactly one fifth", c0, 12);
    full_ref = 0; step(1); probe("R3 zero reference", 0);
    full_ref = 1000; avail = 1000;
    cur = "R4";
    temp_c = -5; step(2); probe("R4 cold three quarters", 12);
    cur = "R5";
    temp_c = 2;  step(2); probe("R5 stays cold below 4", 12);
    temp_c = 4;  step(2); probe("R5 warm at 4", 15);
    cur = "R4";
    temp_c = -25; step(2); probe("R4 deep cold half", 8);
    temp_c = -20; step(2); probe("R4 at -20 three quarters", 12);
    temp_c = 25; step(2);
    cur = "R7";
    eod = 1; step(1);
    win(1600, cc, c0, c1); see("R7 eod blink duty", c0, 240);
    eod = 0; avail = 50; step(1);
    win(1600, cc, c0, c1); see("R7 low charge blink duty", c0, 240);
    avail = 100; step(1);
    win(1600, cc, c0, c1); see("R7 ten percent not low", c0, 0);
    cur = "R12";
    avail = 1000; chg_act = 0; step(1);
    win(40, cc, c0, c1); see("R12 inactive com", cc, 0);
    cur = "R11";
    oce = 1; oc = 5'b01010; step(1);
    win(40, cc, c0, c1);
    see("R11 override com", cc, 24);
    see("R11 override seg1", c0, 0);
    see("R11 override seg2", c1, 12);
    oce = 0; step(1);
    cur = "R8";
    btn_n = 0; step(2); btn_n = 1; step(1);
    win(40, cc, c0, c1); see("R8 button active", cc, 24);
    step(25000);
    win(40, cc, c0, c1); see("R8 near end still active", cc, 24);
    step(1000);
    win(40, cc, c0, c1); see("R8 expired", cc, 0);
    cur = "R9";
    fdis_act = 1; step(10); fdis_act = 0;
    step(63000);
    win(40, cc, c0, c1); see("R9 hold still active", cc, 24);
    step(1000);
    win(40, cc, c0, c1); see("R9 hold expired", cc, 0);
    ovld = 1; step(3); ovld = 0; step(100);
    win(40, cc, c0, c1); see("R9 overload activates", cc, 24);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule